// File: doc/BRIEF.md
# Accumulator ALU with Nibble Carry

This block pairs an 8-bit arithmetic/logic datapath with the 8-bit accumulator that feeds it and the three condition flags it updates. Each executed operation combines the accumulator with a second operand, or acts on the second operand alone. That second operand is either a value read from the register file or an immediate byte. The block returns the result on the same cycle. The result either goes back to the register file through a write port or is captured into the accumulator at the next clock edge.

The flags are carry, nibble carry and zero. Each operation writes its own subset of them and leaves the rest untouched. For subtraction, the carry and nibble carry report "no borrow", so a 1 means the result did not wrap. Rotates move bits through the carry flag. The register file itself and instruction decoding live outside the block.

Top module: `alu_dc8`

## Requirements
- R1: After reset (active-low, asynchronous) the accumulator is 0x00 and the carry, nibble carry and zero flags are all 0.
- R2: Add (op 0) gives acc + operand modulo 256. Carry is the bit-8 carry out. Nibble carry is 1 when the low four bits of the two inputs sum past 0xF. Zero is 1 when the result is 0x00.
- R3: Subtract (op 1) gives operand − acc modulo 256. Carry is 1 exactly when operand ≥ acc (no borrow). Nibble carry is 1 exactly when operand[3:0] ≥ acc[3:0]. Zero is 1 when the result is 0x00.
- R4: AND (op 2), OR (op 3) and XOR (op 4) combine acc with the operand. Complement (op 10) inverts the operand, clear (op 11) yields 0x00, and move (op 12) passes the operand through. All of these update only zero; carry and nibble carry keep their values.
- R5: Rotate left through carry (op 5) yields {operand[6:0], carry}, and the new carry is operand[7]. Rotate right through carry (op 6) yields {carry, operand[7:1]}, and the new carry is operand[0]. Rotates leave nibble carry and zero unchanged.
- R6: Nibble swap (op 7) yields {operand[3:0], operand[7:4]} and changes no flag.
- R7: Increment (op 8) and decrement (op 9) wrap modulo 256 and update only zero.
- R8: When use_imm_i is 1 the operand is imm_i; otherwise it is file_rdata_i.
- R9: When dest_w_i is 1, the result is written to the accumulator and file_we_o stays 0. When dest_w_i is 0, file_we_o is 1 with file_wdata_o equal to the result, and the accumulator is unchanged.
- R10: While valid_i is 0, the accumulator and flags hold and file_we_o is 0.
- R11: Op codes 13, 14 and 15 are reserved. They change no state and never assert file_we_o.
- R12: result_o, file_we_o and file_wdata_o follow the inputs within the same cycle. The accumulator and flags take their new values at the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Execute the presented operation this cycle |
| op_i | input | 4 | Operation code |
| use_imm_i | input | 1 | Select immediate rather than file value as operand |
| imm_i | input | 8 | Immediate operand |
| file_rdata_i | input | 8 | Register-file operand |
| dest_w_i | input | 1 | 1: result to accumulator, 0: result to file |
| result_o | output | 8 | Combinational result |
| file_we_o | output | 1 | Register-file write enable |
| file_wdata_o | output | 8 | Register-file write data |
| w_o | output | 8 | Accumulator value |
| c_o | output | 1 | Carry / no-borrow flag |
| dc_o | output | 1 | Nibble carry / nibble no-borrow flag |
| z_o | output | 1 | Zero flag |

## Verification
The result and the file write strobe are combinational, so they are due in the same cycle the operation is presented. The bench drives inputs on the falling edge and samples those outputs 1 ns later, before the rising edge. The accumulator and the flags are due one rising edge after the operation. The bench reads them 1 ns after that edge and drops valid_i at the same moment, so each check sees exactly one update. Where a flag must hold, the bench snapshots it at the ports beforehand and compares after the edge.

// File: rtl/alu_dc8_pkg.sv
`timescale 1ns/1ps
package alu_dc8_pkg;
  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_AND  = 4'd2,
    OP_OR   = 4'd3,
    OP_XOR  = 4'd4,
    OP_RLC  = 4'd5,
    OP_RRC  = 4'd6,
    OP_SWAP = 4'd7,
    OP_INC  = 4'd8,
    OP_DEC  = 4'd9,
    OP_COM  = 4'd10,
    OP_CLR  = 4'd11,
    OP_MOV  = 4'd12,
    OP_RS13 = 4'd13,
    OP_RS14 = 4'd14,
    OP_RS15 = 4'd15
  } alu_op_e;

  typedef struct packed {
    logic c;
    logic dc;
    logic z;
  } flags_t;
endpackage

// File: rtl/alu_dc8_core.sv
`timescale 1ns/1ps
module alu_dc8_core
  import alu_dc8_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  alu_op_e           op_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic [DATA_W-1:0] opnd_i,
  input  logic              c_i,
  output logic [DATA_W-1:0] res_o,
  output flags_t            flg_o,
  output flags_t            mask_o,
  output logic              known_o
);
  localparam int unsigned NIB_W = DATA_W / 2;

  logic [DATA_W:0] add_s, sub_s;
  logic [NIB_W:0]  add_n, sub_n;

  assign add_s = {1'b0, acc_i} + {1'b0, opnd_i};
  assign add_n = {1'b0, acc_i[NIB_W-1:0]} + {1'b0, opnd_i[NIB_W-1:0]};
  // operand - acc as operand + ~acc + 1; carry out means no borrow
  assign sub_s = {1'b0, opnd_i} + {1'b0, ~acc_i} + (DATA_W+1)'(1);
  assign sub_n = {1'b0, opnd_i[NIB_W-1:0]} + {1'b0, ~acc_i[NIB_W-1:0]} + (NIB_W+1)'(1);

  always_comb begin
    res_o    = '0;
    flg_o.c  = c_i;
    flg_o.dc = 1'b0;
    mask_o   = '0;
    known_o  = 1'b1;
    case (op_i)
      OP_ADD: begin
        res_o = add_s[DATA_W-1:0]; flg_o.c = add_s[DATA_W]; flg_o.dc = add_n[NIB_W];
        mask_o = '{c: 1'b1, dc: 1'b1, z: 1'b1};
      end
      OP_SUB: begin
        res_o = sub_s[DATA_W-1:0]; flg_o.c = sub_s[DATA_W]; flg_o.dc = sub_n[NIB_W];
        mask_o = '{c: 1'b1, dc: 1'b1, z: 1'b1};
      end
      OP_AND:  begin res_o = acc_i & opnd_i; mask_o.z = 1'b1; end
      OP_OR:   begin res_o = acc_i | opnd_i; mask_o.z = 1'b1; end
      OP_XOR:  begin res_o = acc_i ^ opnd_i; mask_o.z = 1'b1; end
      OP_RLC: begin
        res_o = {opnd_i[DATA_W-2:0], c_i}; flg_o.c = opnd_i[DATA_W-1]; mask_o.c = 1'b1;
      end
      OP_RRC: begin
        res_o = {c_i, opnd_i[DATA_W-1:1]}; flg_o.c = opnd_i[0]; mask_o.c = 1'b1;
      end
      OP_SWAP: res_o = {opnd_i[NIB_W-1:0], opnd_i[DATA_W-1:NIB_W]};
      OP_INC:  begin res_o = opnd_i + DATA_W'(1); mask_o.z = 1'b1; end
      OP_DEC:  begin res_o = opnd_i - DATA_W'(1); mask_o.z = 1'b1; end
      OP_COM:  begin res_o = ~opnd_i; mask_o.z = 1'b1; end
      OP_CLR:  begin res_o = '0; mask_o.z = 1'b1; end
      OP_MOV:  begin res_o = opnd_i; mask_o.z = 1'b1; end
      default: known_o = 1'b0;
    endcase
    flg_o.z = ~|res_o;
  end
endmodule

// File: rtl/alu_dc8_state.sv
`timescale 1ns/1ps
module alu_dc8_state
  import alu_dc8_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              wr_acc_i,
  input  logic [DATA_W-1:0] res_i,
  input  flags_t            flg_i,
  input  flags_t            mask_i,
  output logic [DATA_W-1:0] acc_o,
  output flags_t            flg_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_o <= '0;
      flg_o <= '0;
    end else if (en_i) begin
      if (wr_acc_i) acc_o    <= res_i;
      if (mask_i.c)  flg_o.c  <= flg_i.c;
      if (mask_i.dc) flg_o.dc <= flg_i.dc;
      if (mask_i.z)  flg_o.z  <= flg_i.z;
    end
  end
endmodule

// File: rtl/alu_dc8.sv
`timescale 1ns/1ps
module alu_dc8
  import alu_dc8_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [3:0]        op_i,
  input  logic              use_imm_i,
  input  logic [DATA_W-1:0] imm_i,
  input  logic [DATA_W-1:0] file_rdata_i,
  input  logic              dest_w_i,
  output logic [DATA_W-1:0] result_o,
  output logic              file_we_o,
  output logic [DATA_W-1:0] file_wdata_o,
  output logic [DATA_W-1:0] w_o,
  output logic              c_o,
  output logic              dc_o,
  output logic              z_o
);
  logic [DATA_W-1:0] opnd, res, acc;
  flags_t            flg_new, flg_q, mask;
  logic              known, exec;

  assign opnd = use_imm_i ? imm_i : file_rdata_i;

  alu_dc8_core #(.DATA_W(DATA_W)) i_core (
    .op_i   (alu_op_e'(op_i)),
    .acc_i  (acc),
    .opnd_i (opnd),
    .c_i    (flg_q.c),
    .res_o  (res),
    .flg_o  (flg_new),
    .mask_o (mask),
    .known_o(known)
  );

  assign exec = valid_i & known;

  alu_dc8_state #(.DATA_W(DATA_W)) i_state (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (exec),
    .wr_acc_i(dest_w_i),
    .res_i   (res),
    .flg_i   (flg_new),
    .mask_i  (mask),
    .acc_o   (acc),
    .flg_o   (flg_q)
  );

  assign result_o     = res;
  assign file_wdata_o = res;
  assign file_we_o    = exec & ~dest_w_i;
  assign w_o          = acc;
  assign c_o          = flg_q.c;
  assign dc_o         = flg_q.dc;
  assign z_o          = flg_q.z;
endmodule

// File: rtl/alu_dc8_chk.sv
`timescale 1ns/1ps
module alu_dc8_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       valid_i,
  input logic [3:0] op_i,
  input logic       dest_w_i,
  input logic       file_we_o,
  input logic [7:0] result_o,
  input logic [7:0] w_o,
  input logic       c_o,
  input logic       dc_o,
  input logic       z_o
);
  a_r10_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable({w_o, c_o, dc_o, z_o}));

  a_r10_idle_no_we: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> !file_we_o);

  a_r9_file_keeps_acc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !dest_w_i) |=> $stable(w_o));

  a_r9_acc_gets_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && dest_w_i && op_i < 4'd13) |=> (w_o == $past(result_o)));

  a_r6_swap_keeps_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 4'd7) |=> $stable({c_o, dc_o, z_o}));

  a_r5_rot_keeps_dc_z: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (op_i == 4'd5 || op_i == 4'd6)) |=> $stable({dc_o, z_o}));

  a_r4_logic_keeps_c_dc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (op_i inside {4'd2, 4'd3, 4'd4, 4'd8, 4'd9, 4'd10, 4'd11, 4'd12}))
    |=> $stable({c_o, dc_o}));

  a_r2_add_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && dest_w_i && op_i == 4'd0) |=> (z_o == (w_o == 8'h00)));

  a_r11_rsv_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i >= 4'd13) |=> $stable({w_o, c_o, dc_o, z_o}));
endmodule

bind alu_dc8 alu_dc8_chk i_alu_dc8_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .valid_i  (valid_i),
  .op_i     (op_i),
  .dest_w_i (dest_w_i),
  .file_we_o(file_we_o),
  .result_o (result_o),
  .w_o      (w_o),
  .c_o      (c_o),
  .dc_o     (dc_o),
  .z_o      (z_o)
);

// File: tb/test_alu_dc8.sv
`timescale 1ns/1ps
module test_alu_dc8;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       valid_i = 1'b0;
  logic [3:0] op_i = 4'd0;
  logic       use_imm_i = 1'b0;
  logic [7:0] imm_i = 8'h00;
  logic [7:0] file_rdata_i = 8'h00;
  logic       dest_w_i = 1'b1;
  logic [7:0] result_o, file_wdata_o, w_o;
  logic       file_we_o, c_o, dc_o, z_o;

  int total = 0;
  int bad = 0;
  logic [7:0] res_s, wd_s;
  logic       we_s;

  always #2 clk_i = ~clk_i;

  alu_dc8 i_alu_dc8 (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i),
    .use_imm_i(use_imm_i), .imm_i(imm_i), .file_rdata_i(file_rdata_i),
    .dest_w_i(dest_w_i), .result_o(result_o), .file_we_o(file_we_o),
    .file_wdata_o(file_wdata_o), .w_o(w_o), .c_o(c_o), .dc_o(dc_o), .z_o(z_o)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic do_op(input logic [3:0] op, input logic [7:0] fv, input logic dw,
                       input logic im = 1'b0, input logic [7:0] iv = 8'h00,
                       input logic vld = 1'b1);
    @(negedge clk_i);
    op_i = op; file_rdata_i = fv; dest_w_i = dw; use_imm_i = im; imm_i = iv; valid_i = vld;
    #1;
    res_s = result_o; we_s = file_we_o; wd_s = file_wdata_o;
    @(posedge clk_i);
    #1;
    valid_i = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 acc", w_o, 8'h00);
    chk("R1 flags", {5'd0, c_o, dc_o, z_o}, 8'h00);
  endtask

  task automatic t_add;
    do_op(4'd12, 8'h3A, 1'b1);
    do_op(4'd0, 8'hC6, 1'b1);
    chk("R2 sum wrap", w_o, 8'h00);
    chk("R2 flags c dc z", {5'd0, c_o, dc_o, z_o}, 8'h07);
    do_op(4'd12, 8'h12, 1'b1);
    do_op(4'd0, 8'h34, 1'b1);
    chk("R2 sum", w_o, 8'h46);
    chk("R2 flags clear", {5'd0, c_o, dc_o, z_o}, 8'h00);
  endtask

  task automatic t_sub;
    do_op(4'd12, 8'h05, 1'b1);
    do_op(4'd1, 8'h03, 1'b1);
    chk("R3 borrow result", w_o, 8'hFE);
    chk("R3 borrow flags", {5'd0, c_o, dc_o, z_o}, 8'h00);
    do_op(4'd12, 8'h05, 1'b1);
    do_op(4'd1, 8'h05, 1'b1);
    chk("R3 equal result", w_o, 8'h00);
    chk("R3 equal flags", {5'd0, c_o, dc_o, z_o}, 8'h07);
    do_op(4'd12, 8'h18, 1'b1);
    do_op(4'd1, 8'h21, 1'b1);
    chk("R3 nibble borrow result", w_o, 8'h09);
    chk("R3 nibble borrow flags", {5'd0, c_o, dc_o, z_o}, 8'h04);
  endtask

  task automatic t_logic;
    logic [1:0] cd;
    cd = {c_o, dc_o};
    do_op(4'd12, 8'hF0, 1'b1);
    do_op(4'd2, 8'h0F, 1'b0);
    chk("R4 and result", res_s, 8'h00);
    chk("R9 file we", {7'd0, we_s}, 8'h01);
    chk("R9 file data", wd_s, 8'h00);
    chk("R9 acc kept", w_o, 8'hF0);
    chk("R4 and zero", {7'd0, z_o}, 8'h01);
    do_op(4'd3, 8'h0F, 1'b1);
    chk("R4 or", w_o, 8'hFF);
    chk("R9 no file we", {7'd0, we_s}, 8'h00);
    chk("R4 or zero", {7'd0, z_o}, 8'h00);
    do_op(4'd4, 8'hFF, 1'b1);
    chk("R4 xor", w_o, 8'h00);
    chk("R4 xor zero", {7'd0, z_o}, 8'h01);
    do_op(4'd10, 8'h55, 1'b1);
    chk("R4 com", w_o, 8'hAA);
    do_op(4'd11, 8'h77, 1'b1);
    chk("R4 clr", w_o, 8'h00);
    chk("R4 clr zero", {7'd0, z_o}, 8'h01);
    chk("R4 c dc kept", {6'd0, c_o, dc_o}, {6'd0, cd});
  endtask

  task automatic t_incdec;
    logic [1:0] cd;
    cd = {c_o, dc_o};
    do_op(4'd8, 8'hFF, 1'b1);
    chk("R7 inc wrap", w_o, 8'h00);
    chk("R7 inc zero", {7'd0, z_o}, 8'h01);
    do_op(4'd9, 8'h00, 1'b1);
    chk("R7 dec wrap", w_o, 8'hFF);
    chk("R7 dec zero", {7'd0, z_o}, 8'h00);
    do_op(4'd8, 8'h7F, 1'b1);
    chk("R7 inc", w_o, 8'h80);
    chk("R7 c dc kept", {6'd0, c_o, dc_o}, {6'd0, cd});
  endtask

  task automatic t_rot;
    do_op(4'd12, 8'h00, 1'b1);
    do_op(4'd1, 8'h00, 1'b1);
    do_op(4'd12, 8'h01, 1'b1);
    do_op(4'd5, 8'h40, 1'b1);
    chk("R5 rlc in", w_o, 8'h81);
    chk("R5 rlc flags", {5'd0, c_o, dc_o, z_o}, 8'h02);
    do_op(4'd5, 8'h80, 1'b1);
    chk("R5 rlc out", w_o, 8'h00);
    chk("R5 rlc z kept", {5'd0, c_o, dc_o, z_o}, 8'h06);
    do_op(4'd6, 8'h01, 1'b1);
    chk("R5 rrc in", w_o, 8'h80);
    chk("R5 rrc c", {7'd0, c_o}, 8'h01);
    do_op(4'd6, 8'h02, 1'b1);
    chk("R5 rrc out", w_o, 8'h81);
    chk("R5 rrc flags", {5'd0, c_o, dc_o, z_o}, 8'h02);
  endtask

  task automatic t_swap;
    logic [2:0] f;
    f = {c_o, dc_o, z_o};
    do_op(4'd7, 8'hA5, 1'b1);
    chk("R6 swap", w_o, 8'h5A);
    chk("R6 flags kept", {5'd0, c_o, dc_o, z_o}, {5'd0, f});
  endtask

  task automatic t_imm;
    do_op(4'd12, 8'h22, 1'b1, 1'b1, 8'h11);
    chk("R8 imm mov", w_o, 8'h11);
    do_op(4'd0, 8'h22, 1'b1, 1'b1, 8'h01);
    chk("R8 imm add", w_o, 8'h12);
    do_op(4'd0, 8'h22, 1'b1, 1'b0, 8'h01);
    chk("R8 file add", w_o, 8'h34);
  endtask

  task automatic t_idle;
    logic [10:0] s;
    s = {w_o, c_o, dc_o, z_o};
    do_op(4'd11, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0);
    chk("R10 no we", {7'd0, we_s}, 8'h00);
    chk("R10 acc held", w_o, s[10:3]);
    chk("R10 flags held", {5'd0, c_o, dc_o, z_o}, {5'd0, s[2:0]});
  endtask

  task automatic t_rsv;
    logic [10:0] s;
    s = {w_o, c_o, dc_o, z_o};
    for (int k = 13; k < 16; k++) begin
      do_op(4'(k), 8'h00, 1'b0);
      chk("R11 no we", {7'd0, we_s}, 8'h00);
      do_op(4'(k), 8'h00, 1'b1);
      chk("R11 acc held", w_o, s[10:3]);
      chk("R11 flags held", {5'd0, c_o, dc_o, z_o}, {5'd0, s[2:0]});
    end
  endtask

  task automatic t_timing;
    do_op(4'd12, 8'h3C, 1'b1);
    @(negedge clk_i);
    op_i = 4'd0; file_rdata_i = 8'h01; dest_w_i = 1'b1; use_imm_i = 1'b0; valid_i = 1'b1;
    #1;
    chk("R12 comb result", result_o, 8'h3D);
    chk("R12 acc not yet", w_o, 8'h3C);
    @(posedge clk_i);
    #1;
    valid_i = 1'b0;
    chk("R12 acc after edge", w_o, 8'h3D);
  endtask

  initial begin
    #(200000 * 4);
    bad++; total++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    t_reset();
    rst_ni = 1'b1;
    @(posedge clk_i);
    #1;
    t_reset();
    t_add();
    t_sub();
    t_logic();
    t_incdec();
    t_rot();
    t_swap();
    t_imm();
    t_idle();
    t_rsv();
    t_timing();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule